// File: doc/BRIEF.md
# Block-Wise Memory Self-Test Engine

This engine checks every byte of a byte-addressable memory that sits behind a burst-oriented read/write port. It divides the address space into equal sections of one block each (1024 bytes by default). For each section it issues a write burst that fills the section with a fixed pattern. It then issues a read burst over the same section and compares every returned byte with the pattern. A clean section is followed by the next one higher in memory, and the run ends after the last section. The pattern depends only on a byte's offset within its block, so every section holds identical data.

The memory port uses a command handshake: `cmd_valid` and `cmd_ready`, with a write flag and a block-aligned base address. Data then moves one byte per `wr_take` strobe on a write, or one byte per `rd_valid` strobe on a read. A `burst_done` pulse closes the burst. The engine never issues a command while a burst is open. On the first miscompare it raises `fail` and freezes the failing address, the expected byte and the byte read. It lets the open read burst drain, then ends the run without further commands. A host starts a run with a one-cycle `start` pulse. It then waits for the one-cycle `done` pulse and reads `pass` or `fail`.

Top module: `mbist_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy`, `done`, `pass`, `fail` and `cmd_valid` are all 0.
- R2: A `start` pulse while idle raises `cmd_valid` with `cmd_write`=1 and `cmd_addr`=0 in the next cycle. A `start` while busy has no effect: the run neither restarts nor repeats any command.
- R3: The byte written at offset k of every block (k = 0 … 1023) is k[7:0] XOR k[15:8], so with 1024-byte blocks it is k[7:0] XOR {6'b0, k[9:8]}.
- R4: Commands alternate write then read on the same base address. Bases start at 0 and rise by BLOCK_BYTES per section, and the low log2(BLOCK_BYTES) address bits are always 0. A clean run issues exactly 2·MEM_BYTES/BLOCK_BYTES commands.
- R5: `cmd_valid` is never high between an accepted command and its `burst_done`. While `cmd_ready` is low, `cmd_valid`, `cmd_write` and `cmd_addr` hold steady.
- R6: When every section reads back clean, `done` is high for exactly one cycle, and `pass`=1 and `fail`=0 at that point.
- R7: The first byte that reads back different from the pattern sets `fail` and latches `fail_addr` (section base plus offset), `fail_exp` and `fail_got`. Later miscompares leave these unchanged. No command follows the failing read burst, and `done` pulses after that burst's `burst_done`.
- R8: `pass`, `fail` and the latched fail fields stay constant from `done` until the next accepted `start`, which clears `pass` and `fail` in the following cycle. `pass` and `fail` are never both 1.
- R9: `busy` is high from the cycle after an accepted `start` until the run ends, and falls in the same cycle that `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run covered all memory with no miscompare |
| fail | output | 1 | A miscompare was found |
| fail_addr | output | log2(MEM_BYTES) | Byte address of the first miscompare |
| fail_exp | output | 8 | Pattern byte expected there |
| fail_got | output | 8 | Byte actually read there |
| cmd_valid | output | 1 | Burst command offered |
| cmd_write | output | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | output | log2(MEM_BYTES) | Block-aligned burst base address |
| cmd_ready | input | 1 | Memory accepts the command |
| wr_byte | output | 8 | Next byte of the write burst |
| wr_take | input | 1 | Memory consumes `wr_byte` this cycle |
| rd_valid | input | 1 | `rd_byte` carries the next byte of the read burst |
| rd_byte | input | 8 | Read data |
| burst_done | input | 1 | Memory closes the current burst |

## Verification
The properties assume that the memory side obeys the burst protocol. `burst_done` comes only after an accepted command. Exactly one block of `wr_take` or `rd_valid` strobes falls between a command and its `burst_done`. `start` is only pulsed while idle or ignored by design. The bench's memory model enforces this. It grants a command only when `cmd_valid` is seen, streams exactly 1024 strobes (optionally with idle gaps), and then issues a single `burst_done`. It pulses `start` mid-run only to confirm that such a pulse is ignored. Injected faults are XOR masks applied to read data at chosen addresses, so the memory's stored contents stay intact between runs.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_CMD,
        ST_WR_DATA,
        ST_RD_CMD,
        ST_RD_DATA,
        ST_FIN
    } mb_state_e;

    typedef struct packed {
        logic       hit;
        logic [7:0] expect_b;
        logic [7:0] got_b;
    } mb_cmp_t;

    // Pattern byte for a block offset: low byte folded with the next byte.
    function automatic logic [7:0] fold_byte(input logic [15:0] k);
        return k[7:0] ^ k[15:8];
    endfunction

endpackage

// File: rtl/mbist_pattern.sv
module mbist_pattern #(
    parameter int OFS_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [OFS_W-1:0] ofs,
    output logic [7:0]       pat
);
    import mbist_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ofs <= '0;
        end else if (step) begin
            ofs <= ofs + 1'b1;
        end
    end

    generate
        if (OFS_W > 8) begin : g_fold
            always_comb pat = fold_byte(16'(ofs));
        end else begin : g_plain
            always_comb pat = 8'(ofs);
        end
    endgenerate

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic [7:0]        rd_byte,
    input  logic [7:0]        pat,
    input  logic [ADDR_W-1:0] addr_now,
    output logic              err_q,
    output logic              err_any,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [7:0]        fail_exp,
    output logic [7:0]        fail_got
);
    import mbist_pkg::*;

    mb_cmp_t cur;

    always_comb begin
        cur.expect_b = pat;
        cur.got_b    = rd_byte;
        cur.hit      = sample && (rd_byte != pat);
    end

    assign err_any = err_q || cur.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q     <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_got  <= '0;
        end else if (clear) begin
            err_q <= 1'b0;
        end else if (cur.hit && !err_q) begin
            err_q     <= 1'b1;
            fail_addr <= addr_now;
            fail_exp  <= cur.expect_b;
            fail_got  <= cur.got_b;
        end
    end

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq #(
    parameter int NUM_SECT = 256,
    parameter int SECT_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     cmd_ready,
    input  logic                     burst_done,
    input  logic                     err_any,
    output mbist_pkg::mb_state_e     state,
    output logic [SECT_W-1:0]        sect,
    output logic                     start_ok,
    output logic                     cmd_valid,
    output logic                     cmd_write,
    output logic                     busy,
    output logic                     done,
    output logic                     pass
);
    import mbist_pkg::*;

    localparam logic [SECT_W-1:0] LAST_SECT = SECT_W'(NUM_SECT - 1);

    mb_state_e nxt;

    assign start_ok  = (state == ST_IDLE) && start;
    assign cmd_valid = (state == ST_WR_CMD) || (state == ST_RD_CMD);
    assign cmd_write = (state == ST_WR_CMD);
    assign busy      = (state != ST_IDLE) && (state != ST_FIN);
    assign done      = (state == ST_FIN);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (start)      nxt = ST_WR_CMD;
            ST_WR_CMD:  if (cmd_ready)  nxt = ST_WR_DATA;
            ST_WR_DATA: if (burst_done) nxt = ST_RD_CMD;
            ST_RD_CMD:  if (cmd_ready)  nxt = ST_RD_DATA;
            ST_RD_DATA: begin
                if (burst_done) begin
                    if (err_any || sect == LAST_SECT) nxt = ST_FIN;
                    else                              nxt = ST_WR_CMD;
                end
            end
            ST_FIN:     nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sect  <= '0;
            pass  <= 1'b0;
        end else begin
            state <= nxt;
            if (start_ok) begin
                sect <= '0;
                pass <= 1'b0;
            end else if (state == ST_RD_DATA && burst_done) begin
                if (!err_any && sect == LAST_SECT) pass <= 1'b1;
                if (!err_any && sect != LAST_SECT) sect <= sect + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mbist_engine.sv
module mbist_engine #(
    parameter int  MEM_BYTES   = 262144,
    parameter int  BLOCK_BYTES = 1024,
    localparam int ADDR_W      = $clog2(MEM_BYTES),
    localparam int OFS_W       = $clog2(BLOCK_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [7:0]        fail_exp,
    output logic [7:0]        fail_got,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_ready,
    output logic [7:0]        wr_byte,
    input  logic              wr_take,
    input  logic              rd_valid,
    input  logic [7:0]        rd_byte,
    input  logic              burst_done
);
    import mbist_pkg::*;

    localparam int NUM_SECT = MEM_BYTES / BLOCK_BYTES;
    localparam int SECT_W   = ADDR_W - OFS_W;

    mb_state_e          state;
    logic [SECT_W-1:0]  sect;
    logic [OFS_W-1:0]   ofs;
    logic [7:0]         pat;
    logic               start_ok;
    logic               err_q;
    logic               err_any;
    logic               step;
    logic               sample;

    assign step     = (state == ST_WR_DATA && wr_take) || sample;
    assign sample   = (state == ST_RD_DATA) && rd_valid;
    assign cmd_addr = {sect, {OFS_W{1'b0}}};
    assign wr_byte  = pat;
    assign fail     = err_q;

    mbist_seq #(
        .NUM_SECT (NUM_SECT),
        .SECT_W   (SECT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmd_ready  (cmd_ready),
        .burst_done (burst_done),
        .err_any    (err_any),
        .state      (state),
        .sect       (sect),
        .start_ok   (start_ok),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .busy       (busy),
        .done       (done),
        .pass       (pass)
    );

    mbist_pattern #(
        .OFS_W (OFS_W)
    ) u_pat (
        .clk   (clk),
        .rst   (rst),
        .clear (cmd_valid && cmd_ready),
        .step  (step),
        .ofs   (ofs),
        .pat   (pat)
    );

    mbist_cmp #(
        .ADDR_W (ADDR_W)
    ) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_ok),
        .sample    (sample && !err_q),
        .rd_byte   (rd_byte),
        .pat       (pat),
        .addr_now  ({sect, ofs}),
        .err_q     (err_q),
        .err_any   (err_any),
        .fail_addr (fail_addr),
        .fail_exp  (fail_exp),
        .fail_got  (fail_got)
    );

endmodule

// File: rtl/mbist_engine_chk.sv
module mbist_engine_chk #(
    parameter int ADDR_W = 18,
    parameter int OFS_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_write,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              burst_done,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [7:0]        fail_exp,
    input logic [7:0]        fail_got
);
    logic inflight;

    always_ff @(posedge clk) begin
        if (rst)                         inflight <= 1'b0;
        else if (cmd_valid && cmd_ready) inflight <= 1'b1;
        else if (burst_done)             inflight <= 1'b0;
    end

    a_r5_no_cmd_in_flight: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !inflight);

    a_r5_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_write)));

    a_r4_cmd_aligned: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_addr[OFS_W-1:0] == '0));

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_busy_falls_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    a_r8_pass_held: assert property (@(posedge clk) disable iff (rst)
        (pass && !start) |=> pass);

    a_r8_fail_held: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> (fail && $stable(fail_addr) && $stable(fail_exp) && $stable(fail_got)));

    a_r7_no_cmd_after_fail: assert property (@(posedge clk) disable iff (rst)
        fail |-> !cmd_valid);

endmodule

bind mbist_engine mbist_engine_chk #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .fail       (fail),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_write  (cmd_write),
    .cmd_addr   (cmd_addr),
    .burst_done (burst_done),
    .fail_addr  (fail_addr),
    .fail_exp   (fail_exp),
    .fail_got   (fail_got)
);

// File: tb/sim_mbist_engine.sv
`timescale 1ns/1ps
module sim_mbist_engine;

    localparam int TB_MEM = 4096;
    localparam int TB_BLK = 1024;
    localparam int AW     = 12;
    localparam int NSEC   = TB_MEM / TB_BLK;

    typedef struct packed {
        logic [15:0] fa;
        logic [7:0]  xa;
        logic [15:0] fb;
        logic [7:0]  xb;
        logic        gap;
    } tv_t;

    localparam tv_t VECS [5] = '{
        '{16'h0000, 8'h00, 16'h0000, 8'h00, 1'b0},
        '{16'h0000, 8'h01, 16'h0000, 8'h00, 1'b1},
        '{16'h0FFF, 8'h80, 16'h0000, 8'h00, 1'b0},
        '{16'h0855, 8'h10, 16'h0900, 8'hFF, 1'b1},
        '{16'h0000, 8'h00, 16'h0000, 8'h00, 1'b1}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          busy, done, pass, fail;
    logic [AW-1:0] fail_addr;
    logic [7:0]    fail_exp, fail_got;
    logic          cmd_valid, cmd_write;
    logic [AW-1:0] cmd_addr;
    logic          cmd_ready = 1'b0;
    logic [7:0]    wr_byte;
    logic          wr_take = 1'b0;
    logic          rd_valid = 1'b0;
    logic [7:0]    rd_byte = 8'h00;
    logic          burst_done = 1'b0;

    mbist_engine #(.MEM_BYTES(TB_MEM), .BLOCK_BYTES(TB_BLK)) u0 (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .pass(pass), .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp),
        .fail_got(fail_got), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .wr_byte(wr_byte),
        .wr_take(wr_take), .rd_valid(rd_valid), .rd_byte(rd_byte),
        .burst_done(burst_done)
    );

    int checks = 0;
    int fails  = 0;

    int cmd_cnt, order_err, pat_err, r5_err;
    int f1, f2;
    logic [7:0] x1, x2;
    bit gap_on;
    logic [7:0] mem [TB_MEM];

    function automatic logic [7:0] pat_of(input int k);
        logic [15:0] kk;
        kk = 16'(k);
        return kk[7:0] ^ kk[15:8];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model: grants a command, streams one block, closes the burst.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && cmd_valid) begin
                bit w;
                int base;
                w    = cmd_write;
                base = int'(cmd_addr);
                if (w != (cmd_cnt % 2 == 0) || base != (cmd_cnt / 2) * TB_BLK) order_err++;
                cmd_cnt++;
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                for (int i = 0; i < TB_BLK; i++) begin
                    if (gap_on && (i % 4) == 3) begin
                        if (cmd_valid) r5_err++;
                        @(negedge clk);
                    end
                    if (cmd_valid) r5_err++;
                    if (w) begin
                        mem[base + i] = wr_byte;
                        if (wr_byte != pat_of(i)) pat_err++;
                        wr_take = 1'b1;
                    end else begin
                        logic [7:0] b;
                        b = mem[base + i];
                        if (x1 != 0 && base + i == f1) b = b ^ x1;
                        if (x2 != 0 && base + i == f2) b = b ^ x2;
                        rd_byte  = b;
                        rd_valid = 1'b1;
                    end
                    @(negedge clk);
                    wr_take  = 1'b0;
                    rd_valid = 1'b0;
                end
                burst_done = 1'b1;
                @(negedge clk);
                burst_done = 1'b0;
            end
        end
    end

    task automatic run_case(input tv_t v, input bit mid_start);
        bit exp_fail;
        int faddr, n, exp_cmds;
        logic [7:0] fx, e_exp;
        cmd_cnt = 0; order_err = 0; pat_err = 0; r5_err = 0;
        f1 = int'(v.fa); x1 = v.xa; f2 = int'(v.fb); x2 = v.xb; gap_on = v.gap;
        exp_fail = (x1 != 0) || (x2 != 0);
        faddr = f1; fx = x1;
        if (x1 == 0 || (x2 != 0 && f2 < f1)) begin faddr = f2; fx = x2; end
        exp_cmds = exp_fail ? 2 * (faddr / TB_BLK + 1) : 2 * NSEC;
        e_exp = pat_of(faddr % TB_BLK);

        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
        chk(pass == 1'b0 && fail == 1'b0, "R8", "pass/fail cleared by start",
            int'({pass, fail}), 0);
        chk(cmd_valid && cmd_write && cmd_addr == '0, "R2", "first command write@0",
            int'({cmd_valid, cmd_write, cmd_addr}), int'({1'b1, 1'b1, 12'h000}));
        if (mid_start) begin
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 40000) begin @(negedge clk); n++; end
        chk(done == 1'b1, "R6", "done reached", int'(done), 1);
        chk(busy == 1'b0, "R9", "busy low with done", int'(busy), 0);
        chk(pass == !exp_fail && fail == exp_fail, exp_fail ? "R7" : "R6", "pass/fail",
            int'({pass, fail}), int'({!exp_fail, exp_fail}));
        chk(cmd_cnt == exp_cmds, mid_start ? "R2" : "R4", "command count", cmd_cnt, exp_cmds);
        chk(order_err == 0, "R4", "command order/address", order_err, 0);
        chk(pat_err == 0, "R3", "written pattern bytes", pat_err, 0);
        chk(r5_err == 0, "R5", "command during open burst", r5_err, 0);
        if (exp_fail) begin
            chk(int'(fail_addr) == faddr, "R7", "fail_addr", int'(fail_addr), faddr);
            chk(fail_exp == e_exp, "R7", "fail_exp", int'(fail_exp), int'(e_exp));
            chk(fail_got == (e_exp ^ fx), "R7", "fail_got", int'(fail_got), int'(e_exp ^ fx));
        end
        @(negedge clk);
        chk(done == 1'b0, "R6", "done is one cycle", int'(done), 0);
        repeat (5) @(negedge clk);
        chk(pass == !exp_fail && fail == exp_fail && busy == 1'b0, "R8", "result held",
            int'({busy, pass, fail}), int'({1'b0, !exp_fail, exp_fail}));
        if (exp_fail)
            chk(int'(fail_addr) == faddr, "R8", "fail_addr held", int'(fail_addr), faddr);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        f1 = 0; f2 = 0; x1 = 0; x2 = 0; gap_on = 0;
        cmd_cnt = 0; order_err = 0; pat_err = 0; r5_err = 0;
        // R1: outputs idle under reset, even with start held high
        start = 1'b1;
        repeat (3) @(negedge clk);
        chk({busy, done, pass, fail, cmd_valid} == 5'b0, "R1", "outputs in reset",
            int'({busy, done, pass, fail, cmd_valid}), 0);
        start = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, pass, fail, cmd_valid} == 5'b0, "R1", "outputs after reset",
            int'({busy, done, pass, fail, cmd_valid}), 0);

        for (int v = 0; v < 5; v++) run_case(VECS[v], 1'b0);

        // R2: start during a run is ignored
        run_case('{16'h0000, 8'h00, 16'h0000, 8'h00, 1'b0}, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule